// File: doc/BRIEF.md
# Temperature Threshold Alarm Comparator

This block watches a stream of temperature samples and decides, one sample at a time, whether the reading has crossed a programmable limit. Every sample is a 16-bit two's-complement fixed-point number with six fractional bits, so one step is 1/64 of a degree. The limit uses the same format. A small mode field chooses the direction of the test: at-or-below or at-or-above the limit. The other two codes of the field turn the test off.

The outcome of the most recent test is shown as a live status bit. A match also sets a sticky alarm flag. The flag stays set until software clears it, either through a write-one-to-clear status mask or through a clear command bit in the control word. The interrupt line is the flag gated by an enable bit, so masking the line never loses a pending alarm. A separate sticky bit reports that a fresh sample has arrived.

The sensor front end and the register bus decode sit outside this block. Software-visible words arrive here as already-decoded 32-bit values.

Top module: `thermal_thresh_monitor`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `status_word` reads all zeros and `irq` is low.
- R2: `smp_data` and the limit `thr_word[31:16]` are both 16-bit two's-complement values in 1/64-degree units, and they are compared as signed numbers (for example, 0x8000 is the coldest possible reading).
- R3: The mode field `ctrl_word[3:2]` selects the test. Code 0 matches when sample <= limit. Code 1 matches when sample >= limit. Codes 2 and 3 never match.
- R4: `status_word[13]` (live result) takes the outcome of the test one cycle after a cycle with `smp_valid` high, and holds its value through cycles without `smp_valid`.
- R5: `status_word[9]` (alarm flag) becomes 1 one cycle after a cycle in which `smp_valid` is high and the test matches. It then stays 1 until it is cleared.
- R6: The alarm flag clears one cycle after a cycle with `status_clr[9]` high or `ctrl_word[21]` high. If a match arrives in the same cycle as a clear, the match wins and the flag stays set.
- R7: `irq` equals `status_word[9]` AND `ctrl_word[9]`, with no extra delay. Taking the enable low masks the line but leaves the flag unchanged.
- R8: `status_word[16]` (sample ready) becomes 1 one cycle after any `smp_valid`. It clears one cycle after `status_clr[16]` is high, and a new sample in the same cycle wins over the clear.
- R9: All `status_word` bits other than 9, 13 and 16 read 0. Any `ctrl_word`, `thr_word` or `status_clr` bit not named in R2 to R8 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | One-cycle strobe marking a new sample |
| smp_data | input | 16 | Signed temperature sample, 1/64 degree per LSB |
| ctrl_word | input | 32 | Control word: mode [3:2], interrupt enable [9], flag-clear command [21] |
| thr_word | input | 32 | Threshold word: limit in [31:16] |
| status_clr | input | 32 | Write-one-to-clear strobes: [9] flag, [16] sample ready |
| status_word | output | 32 | Status: flag [9], live result [13], sample ready [16] |
| irq | output | 1 | Alarm interrupt line |

## Verification
The assertions assume that `thr_word` and the mode field are steady in any cycle where `smp_valid` is high. They also assume that the clear strobes are sampled only at clock edges and carry no meaning between edges. The stimulus changes every input a quarter period after the rising edge, and it changes the limit and the mode only together with, or before, the sample that uses them. Under these conditions, each rising edge sees one consistent set of inputs. The mix of inputs covers several cases: values exactly at the limit, one step either side of it, both extremes of the signed range, clear and match arriving in the same cycle, and the two unused mode codes.

// File: rtl/thr_cmp_pkg.sv
package thr_cmp_pkg;

    // Default datapath widths
    localparam int SMP_W_DEF  = 16;
    localparam int WORD_W_DEF = 32;

    // Control word field positions
    localparam int CTRL_MODE_LSB = 2;
    localparam int CTRL_IE_BIT   = 9;
    localparam int CTRL_CLR_BIT  = 21;

    // Threshold word field position
    localparam int THR_LSB = 16;

    // Status word bit positions
    localparam int STAT_FLAG_BIT = 9;
    localparam int STAT_LIVE_BIT = 13;
    localparam int STAT_RDY_BIT  = 16;

    // Sticky bit bank indices
    localparam int STK_FLAG = 0;
    localparam int STK_RDY  = 1;
    localparam int STK_N    = 2;

    typedef enum logic [1:0] {
        CMP_AT_OR_BELOW = 2'd0,
        CMP_AT_OR_ABOVE = 2'd1,
        CMP_OFF_A       = 2'd2,
        CMP_OFF_B       = 2'd3
    } cmp_mode_e;

    typedef struct packed {
        cmp_mode_e mode;
        logic      irq_en;
        logic      clr_cmd;
    } ctrl_fields_t;

    typedef struct packed {
        logic hit;
        logic live;
    } cmp_out_t;

    // Picks the relevant relational outcome for a given mode
    function automatic logic mode_select(input cmp_mode_e m,
                                         input logic     le,
                                         input logic     ge);
        logic r;
        unique case (m)
            CMP_AT_OR_BELOW: r = le;
            CMP_AT_OR_ABOVE: r = ge;
            default:         r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/thr_cfg_decode.sv
module thr_cfg_decode
    import thr_cmp_pkg::*;
#(
    parameter int SMP_W  = SMP_W_DEF,
    parameter int WORD_W = WORD_W_DEF
) (
    input  logic [WORD_W-1:0] ctrl_word,
    input  logic [WORD_W-1:0] thr_word,
    output ctrl_fields_t      fields,
    output logic [SMP_W-1:0]  limit
);
    localparam logic [WORD_W-1:0] CTRL_USED =
        (WORD_W'(3) << CTRL_MODE_LSB) |
        (WORD_W'(1) << CTRL_IE_BIT)   |
        (WORD_W'(1) << CTRL_CLR_BIT);
    localparam logic [WORD_W-1:0] THR_USED =
        ((WORD_W'(1) << SMP_W) - WORD_W'(1)) << THR_LSB;

    always_comb begin
        fields.mode    = cmp_mode_e'(ctrl_word[CTRL_MODE_LSB +: 2]);
        fields.irq_en  = ctrl_word[CTRL_IE_BIT];
        fields.clr_cmd = ctrl_word[CTRL_CLR_BIT];
        limit          = thr_word[THR_LSB +: SMP_W];
    end

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{ctrl_word & ~CTRL_USED, thr_word & ~THR_USED};

endmodule

// File: rtl/thr_compare.sv
module thr_compare
    import thr_cmp_pkg::*;
#(
    parameter int SMP_W = SMP_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic [SMP_W-1:0] limit,
    input  cmp_mode_e        mode,
    output cmp_out_t         res
);
    logic signed [SMP_W-1:0] s_val;
    logic signed [SMP_W-1:0] l_val;
    logic                    le;
    logic                    ge;
    logic                    hit;
    logic                    live_q;

    always_comb begin
        s_val = $signed(smp_data);
        l_val = $signed(limit);
        le    = (s_val <= l_val);
        ge    = (s_val >= l_val);
        hit   = mode_select(mode, le, ge);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= 1'b0;
        end else if (smp_valid) begin
            live_q <= hit;
        end
    end

    always_comb begin
        res.hit  = smp_valid & hit;
        res.live = live_q;
    end

endmodule

// File: rtl/thr_sticky_bank.sv
module thr_sticky_bank #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= 1'b0;
            end else if (set_i[g]) begin
                q <= 1'b1;
            end else if (clr_i[g]) begin
                q <= 1'b0;
            end
        end
        assign q_o[g] = q;
    end

endmodule

// File: rtl/thermal_thresh_monitor.sv
module thermal_thresh_monitor
    import thr_cmp_pkg::*;
#(
    parameter int SMP_W  = SMP_W_DEF,
    parameter int WORD_W = WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_data,
    input  logic [WORD_W-1:0] ctrl_word,
    input  logic [WORD_W-1:0] thr_word,
    input  logic [WORD_W-1:0] status_clr,
    output logic [WORD_W-1:0] status_word,
    output logic              irq
);
    ctrl_fields_t       fields;
    logic [SMP_W-1:0]   limit;
    cmp_out_t           cres;
    logic [STK_N-1:0]   stk_set;
    logic [STK_N-1:0]   stk_clr;
    logic [STK_N-1:0]   stk_q;

    thr_cfg_decode #(.SMP_W(SMP_W), .WORD_W(WORD_W)) u_dec (
        .ctrl_word (ctrl_word),
        .thr_word  (thr_word),
        .fields    (fields),
        .limit     (limit)
    );

    thr_compare #(.SMP_W(SMP_W)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .limit     (limit),
        .mode      (fields.mode),
        .res       (cres)
    );

    always_comb begin
        stk_set           = '0;
        stk_clr           = '0;
        stk_set[STK_FLAG] = cres.hit;
        stk_clr[STK_FLAG] = status_clr[STAT_FLAG_BIT] | fields.clr_cmd;
        stk_set[STK_RDY]  = smp_valid;
        stk_clr[STK_RDY]  = status_clr[STAT_RDY_BIT];
    end

    thr_sticky_bank #(.N(STK_N)) u_stk (
        .clk   (clk),
        .rst   (rst),
        .set_i (stk_set),
        .clr_i (stk_clr),
        .q_o   (stk_q)
    );

    always_comb begin
        status_word                = '0;
        status_word[STAT_FLAG_BIT] = stk_q[STK_FLAG];
        status_word[STAT_LIVE_BIT] = cres.live;
        status_word[STAT_RDY_BIT]  = stk_q[STK_RDY];
        irq                        = stk_q[STK_FLAG] & fields.irq_en;
    end

    logic unused_clr_bits;
    assign unused_clr_bits = ^(status_clr & ~((WORD_W'(1) << STAT_FLAG_BIT) |
                                              (WORD_W'(1) << STAT_RDY_BIT)));

endmodule

// File: rtl/thermal_thresh_monitor_chk.sv
module thermal_thresh_monitor_chk #(
    parameter int SMP_W  = 16,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              smp_valid,
    input logic [SMP_W-1:0]  smp_data,
    input logic [WORD_W-1:0] ctrl_word,
    input logic [WORD_W-1:0] thr_word,
    input logic [WORD_W-1:0] status_clr,
    input logic [WORD_W-1:0] status_word,
    input logic              irq
);
    logic signed [SMP_W-1:0] s_in;
    logic signed [SMP_W-1:0] t_in;
    assign s_in = $signed(smp_data);
    assign t_in = $signed(thr_word[16 +: SMP_W]);

    // R7: line is the flag gated by the enable
    a_r7_irq_gate: assert property (@(posedge clk) disable iff (rst)
        irq == (status_word[9] & ctrl_word[9]));

    // R3 / R5: at-or-above match sets the flag
    a_r5_ge_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && ctrl_word[3:2] == 2'd1 && s_in >= t_in) |=> status_word[9]);

    // R3 / R5: at-or-below match sets the flag
    a_r5_le_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && ctrl_word[3:2] == 2'd0 && s_in <= t_in) |=> status_word[9]);

    // R3: codes 2 and 3 produce a zero live result
    a_r3_off_modes: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && ctrl_word[3]) |=> !status_word[13]);

    // R4: live result holds between samples
    a_r4_live_hold: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(status_word[13]));

    // R5: flag stays set without a clear
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (status_word[9] && !status_clr[9] && !ctrl_word[21]) |=> status_word[9]);

    // R6: clear without a sample drops the flag
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && (status_clr[9] || ctrl_word[21])) |=> !status_word[9]);

    // R8: sample ready follows the strobe
    a_r8_ready_set: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> status_word[16]);

    // R9: reserved status bits read zero
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        $countones(status_word & ~((WORD_W'(1) << 9) | (WORD_W'(1) << 13) |
                                   (WORD_W'(1) << 16))) == 0);

endmodule

bind thermal_thresh_monitor thermal_thresh_monitor_chk #(
    .SMP_W  (SMP_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .smp_valid   (smp_valid),
    .smp_data    (smp_data),
    .ctrl_word   (ctrl_word),
    .thr_word    (thr_word),
    .status_clr  (status_clr),
    .status_word (status_word),
    .irq         (irq)
);

// File: tb/thermal_thresh_monitor_tb.sv
module thermal_thresh_monitor_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic [31:0] ctrl_word = '0;
    logic [31:0] thr_word = '0;
    logic [31:0] status_clr = '0;
    logic [31:0] status_word;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state
    int m_flag = 0;
    int m_live = 0;
    int m_rdy  = 0;

    always #(CLK_P/2) clk = ~clk;

    thermal_thresh_monitor u_dut (
        .clk         (clk),
        .rst         (rst),
        .smp_valid   (smp_valid),
        .smp_data    (smp_data),
        .ctrl_word   (ctrl_word),
        .thr_word    (thr_word),
        .status_clr  (status_clr),
        .status_word (status_word),
        .irq         (irq)
    );

    function automatic int ref_hit(int mode, int s, int t);
        if (mode == 0) return (s <= t) ? 1 : 0;
        if (mode == 1) return (s >= t) ? 1 : 0;
        return 0;
    endfunction

    always @(posedge clk) begin
        int s, t, h, cl;
        if (rst) begin
            m_flag = 0; m_live = 0; m_rdy = 0;
        end else begin
            s  = int'($signed(smp_data));
            t  = int'($signed(thr_word[31:16]));
            h  = ref_hit(int'(ctrl_word[3:2]), s, t);
            cl = (status_clr[9] || ctrl_word[21]) ? 1 : 0;
            if (smp_valid) m_live = h;
            if (smp_valid && h == 1) m_flag = 1;
            else if (cl == 1) m_flag = 0;
            if (smp_valid) m_rdy = 1;
            else if (status_clr[16]) m_rdy = 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        logic [31:0] exp_sw;
        if (!done) begin
            exp_sw = '0;
            exp_sw[9]  = (m_flag != 0);
            exp_sw[13] = (m_live != 0);
            exp_sw[16] = (m_rdy != 0);
            check(status_word[9] == exp_sw[9], "R5/R6 flag", int'(status_word[9]), int'(exp_sw[9]));
            check(status_word[13] == exp_sw[13], "R3/R4 live", int'(status_word[13]), int'(exp_sw[13]));
            check(status_word[16] == exp_sw[16], "R8 ready", int'(status_word[16]), int'(exp_sw[16]));
            check((status_word & 32'hFFFE_DDFF) == 0, "R9 reserved", int'(status_word), int'(exp_sw));
            check(irq == (exp_sw[9] & ctrl_word[9]), "R7 irq", int'(irq), int'(exp_sw[9] & ctrl_word[9]));
        end
    end

    task automatic cyc(input bit v, input logic [15:0] s, input logic [31:0] c,
                       input logic [31:0] t, input logic [31:0] clr);
        @(posedge clk);
        #(CLK_P/4);
        smp_valid  = v;
        smp_data   = s;
        ctrl_word  = c;
        thr_word   = t;
        status_clr = clr;
    endtask

    function automatic logic [31:0] mk_ctrl(int mode, bit en, bit clr);
        logic [31:0] c = '0;
        c[3:2] = mode[1:0];
        c[9]   = en;
        c[21]  = clr;
        return c;
    endfunction

    // Sample outputs right after the next rising edge has taken effect
    task automatic probe(output logic [31:0] sw, output logic ir);
        @(negedge clk);
        sw = status_word;
        ir = irq;
    endtask

    initial begin
        #(CLK_P*100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] sw;
        logic        ir;
        logic [31:0] thr25;
        logic [31:0] thrn;
        thr25 = {16'd1600, 16'h0000};   // 25.0 degrees
        thrn  = {16'hFD60, 16'hFFFF};   // -10.5 degrees, low half is noise (R9)

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(status_word == 0 && irq == 0, "R1 reset", int'(status_word), 0);
        @(posedge clk); #(CLK_P/4); rst = 0;
        @(negedge clk);
        check(status_word == 0 && irq == 0, "R1 first cycle", int'(status_word), 0);

        // R3 GE mode: one step below, then exactly at the limit
        cyc(1, 16'd1599, mk_ctrl(1, 1, 0), thr25, 0);
        cyc(0, 0, mk_ctrl(1, 1, 0), thr25, 0);
        probe(sw, ir);
        check(sw[9] == 0 && sw[16] == 1, "R3 GE below", int'(sw), 32'h0001_0000);
        cyc(1, 16'd1600, mk_ctrl(1, 1, 0), thr25, 0);
        cyc(0, 0, mk_ctrl(1, 1, 0), thr25, 0);
        probe(sw, ir);
        check(sw[9] == 1 && sw[13] == 1 && ir == 1, "R5 GE at limit", int'(sw), 32'h0001_2200);

        // R4: live drops on a non-matching sample, flag stays
        cyc(1, 16'd100, mk_ctrl(1, 1, 0), thr25, 0);
        repeat (3) cyc(0, 16'd5000, mk_ctrl(1, 1, 0), thr25, 0);
        probe(sw, ir);
        check(sw[13] == 0 && sw[9] == 1, "R4 hold / R5 sticky", int'(sw), 32'h0001_0200);

        // R7: masking keeps the flag
        cyc(0, 0, mk_ctrl(1, 0, 0), thr25, 0);
        probe(sw, ir);
        check(ir == 0 && sw[9] == 1, "R7 masked", int'(ir), 0);
        cyc(0, 0, mk_ctrl(1, 1, 0), thr25, 0);
        probe(sw, ir);
        check(ir == 1, "R7 unmasked", int'(ir), 1);

        // R6: write-one-to-clear
        cyc(0, 0, mk_ctrl(1, 1, 0), thr25, 32'h0000_0200);
        cyc(0, 0, mk_ctrl(1, 1, 0), thr25, 0);
        probe(sw, ir);
        check(sw[9] == 0 && ir == 0, "R6 w1c", int'(sw[9]), 0);

        // R6: match and clear together, match wins
        cyc(1, 16'd2000, mk_ctrl(1, 1, 1), thr25, 32'h0000_0200);
        cyc(0, 0, mk_ctrl(1, 1, 0), thr25, 0);
        probe(sw, ir);
        check(sw[9] == 1, "R6 set wins", int'(sw[9]), 1);

        // R6: control-word clear command
        cyc(0, 0, mk_ctrl(1, 1, 1), thr25, 0);
        cyc(0, 0, mk_ctrl(1, 1, 0), thr25, 0);
        probe(sw, ir);
        check(sw[9] == 0, "R6 ctrl clear", int'(sw[9]), 0);

        // R2 / R3 LE mode with a negative limit
        cyc(1, 16'hFD61, mk_ctrl(0, 1, 0), thrn, 0);   // -671: above
        cyc(0, 0, mk_ctrl(0, 1, 0), thrn, 0);
        probe(sw, ir);
        check(sw[9] == 0, "R2 LE neg above", int'(sw[9]), 0);
        cyc(1, 16'hFD5F, mk_ctrl(0, 1, 0), thrn, 0);   // -673: below
        cyc(0, 0, mk_ctrl(0, 1, 0), thrn, 32'h0000_0200);
        probe(sw, ir);
        check(sw[9] == 1 && sw[13] == 1, "R2 LE neg below", int'(sw), 32'h0001_2200);
        cyc(0, 0, mk_ctrl(0, 1, 1), thrn, 0);
        cyc(1, 16'h8000, mk_ctrl(0, 1, 0), thrn, 0);   // coldest reading
        cyc(0, 0, mk_ctrl(0, 1, 0), thrn, 0);
        probe(sw, ir);
        check(sw[9] == 1, "R2 min value", int'(sw[9]), 1);

        // R3: codes 2 and 3 never match, even at the extremes
        cyc(0, 0, mk_ctrl(0, 1, 1), thrn, 0);
        cyc(1, 16'h8000, mk_ctrl(2, 1, 0), {16'h7FFF, 16'h0}, 0);
        cyc(1, 16'h7FFF, mk_ctrl(3, 1, 0), {16'h8000, 16'h0}, 0);
        cyc(1, 16'h0000, mk_ctrl(2, 1, 0), {16'h0000, 16'h0}, 0);
        cyc(0, 0, mk_ctrl(3, 1, 0), 0, 0);
        probe(sw, ir);
        check(sw[9] == 0 && sw[13] == 0 && ir == 0, "R3 off modes", int'(sw), 32'h0001_0000);

        // R8: ready clear, and sample-wins-over-clear
        cyc(0, 0, 0, 0, 32'h0001_0000);
        cyc(0, 0, 0, 0, 0);
        probe(sw, ir);
        check(sw[16] == 0, "R8 clear", int'(sw[16]), 0);
        cyc(1, 16'd1, 0, 0, 32'h0001_0000);
        cyc(0, 0, 0, 0, 0);
        probe(sw, ir);
        check(sw[16] == 1, "R8 set wins", int'(sw[16]), 1);

        // R9: stray bits in every input word have no effect
        cyc(0, 0, 32'hFFDF_FDF3, 32'h0000_FFFF, 32'hFFFE_FDFF);
        cyc(0, 0, 32'hFFDF_FDF3, 32'h0000_FFFF, 0);
        probe(sw, ir);
        check(sw == 32'h0001_0000, "R9 stray bits", int'(sw), 32'h0001_0000);

        // Mixed traffic, model compared every cycle
        for (int i = 0; i < 400; i++) begin
            logic [31:0] c;
            logic [31:0] t;
            logic [31:0] cl;
            c  = $urandom;
            c[21] = ($urandom % 8 == 0);
            t  = {16'($urandom % 64) - 16'd32, 16'($urandom)};
            cl = $urandom & 32'hFFFE_FDFF;
            cl[9]  = ($urandom % 6 == 0);
            cl[16] = ($urandom % 5 == 0);
            cyc(($urandom % 2) == 1, 16'($urandom % 96) - 16'd48, c, t, cl);
        end
        cyc(0, 0, 0, 0, 0);
        @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule